// File: doc/BRIEF.md
# Configurable Macrocell Storage Cell

This block is one output cell of a small programmable logic fabric. It receives a sum-of-products term and a direct pin signal, and it drives one output that returns to the fabric and goes to a pin. Static configuration inputs choose how the cell behaves. It can be a plain combinational pass-through, a D flip-flop, a toggle flip-flop or a level-sensitive latch. The data can come from the logic term or from the pin. The clock can be any of the global clocks or a product-term clock, in either polarity. Registers can optionally update on both clock edges.

The storage element also has several asynchronous controls. A power-on reset loads a per-cell initial value, and so does a global set/reset line when the cell's enable bit is set. Product-term set and reset lines drive the element directly. A product-term clock enable holds the stored value when it is low. The configuration inputs are meant to stay fixed while the cell runs. Changes are made while the power-on reset is held low.

Top module: `mc_macrocell`

## Requirements
- R1: With `cfg_mode` = 0 (pass-through), `mc_out` follows the selected data input combinationally, with no clock involved.
- R2: With `cfg_mode` = 1 (D flip-flop), `mc_out` takes the selected data value on the active edge of the selected clock and keeps it between edges.
- R3: With `cfg_mode` = 2 (toggle flip-flop), `mc_out` inverts on an active edge when the data value is 1 and keeps its value when the data value is 0.
- R4: With `cfg_mode` = 3 (latch), `mc_out` follows the data while the selected clock, after polarity, is high and `pt_ce` is 1. Otherwise it holds the last value.
- R5: With `pt_ce` = 0, an active clock edge leaves the D and toggle registers unchanged.
- R6: With `cfg_dual` = 1, the D and toggle registers update on both the rising and the falling edge of the selected clock.
- R7: `cfg_clk_sel` values 0 to NUM_GCLK-1 select `gclk[i]`, and the value NUM_GCLK selects `pt_clk`. Edges on unselected clocks have no effect. With `cfg_clk_inv` = 1, the falling edge of the source is the active edge.
- R8: With `cfg_src_pin` = 1, the data value is `pin_in`; with 0 it is `sop_in`.
- R9: While `por_n` is 0 and after it is released, a registered cell outputs `cfg_init`.
- R10: `gsr` = 1 with `cfg_gsr_en` = 1 asynchronously forces a registered cell to `cfg_init`. With `cfg_gsr_en` = 0, `gsr` has no effect.
- R11: `pt_set` asynchronously forces 1 and `pt_rst` forces 0. Any clearing source beats any setting source, and all of them override clocked updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| gclk | input | NUM_GCLK | Global clocks |
| pt_clk | input | 1 | Product-term clock |
| sop_in | input | 1 | Sum-of-products data term |
| pin_in | input | 1 | Direct pin data |
| pt_ce | input | 1 | Product-term clock enable |
| pt_set | input | 1 | Product-term asynchronous set |
| pt_rst | input | 1 | Product-term asynchronous reset |
| gsr | input | 1 | Global set/reset line |
| cfg_mode | input | 2 | 0 pass, 1 D, 2 toggle, 3 latch |
| cfg_src_pin | input | 1 | 1 selects pin_in as data |
| cfg_clk_sel | input | CSEL_W | Clock source index |
| cfg_clk_inv | input | 1 | Invert the selected clock |
| cfg_dual | input | 1 | Update on both clock edges |
| cfg_init | input | 1 | Power-up and global set/reset value |
| cfg_gsr_en | input | 1 | Let gsr act on this cell |
| mc_out | output | 1 | Cell output |

## Verification
Each mode is driven with data patterns that separate it from its neighbours:
- D and toggle registers get a data value of 1 on repeated edges. D holds at 1 while toggle alternates.
- A data value of 0 on an edge leaves the toggle register unchanged but updates the D register.

Clock selection is checked by pulsing both a selected and an unselected clock, and by running the same data across single-edge and dual-edge configurations. Latch and flip-flop behaviour are told apart by changing data while the gate is open. The asynchronous controls are stacked against each other and against clock edges, which exposes the priority order.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
    typedef enum logic [1:0] {
        MC_COMB  = 2'd0,
        MC_DFF   = 2'd1,
        MC_TFF   = 2'd2,
        MC_LATCH = 2'd3
    } mc_mode_e;
endpackage

// File: rtl/mc_clock_select.sv
`timescale 1ns/1ps
module mc_clock_select #(
    parameter int NUM_GCLK = 3,
    localparam int CSEL_W = $clog2(NUM_GCLK + 1)
) (
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic [CSEL_W-1:0]   sel,
    input  logic                inv,
    output logic                eclk
);
    logic raw_clk;

    // Default is the product-term clock; an index below NUM_GCLK picks a global one.
    always_comb begin
        raw_clk = pt_clk;
        for (int i = 0; i < NUM_GCLK; i++) begin
            if (sel == CSEL_W'(i)) raw_clk = gclk[i];
        end
    end

    assign eclk = raw_clk ^ inv;
endmodule

// File: rtl/mc_async_ctrl.sv
`timescale 1ns/1ps
module mc_async_ctrl (
    input  logic por_n,
    input  logic init_val,
    input  logic gsr,
    input  logic gsr_en,
    input  logic pt_set,
    input  logic pt_rst,
    output logic aclr,
    output logic apre
);
    logic load_init;

    assign load_init = ~por_n | (gsr & gsr_en);
    assign aclr      = pt_rst | (load_init & ~init_val);
    // Gated so that a set still present when a clear ends produces a new event.
    assign apre      = (pt_set | (load_init & init_val)) & ~aclr;
endmodule

// File: rtl/mc_next_state.sv
`timescale 1ns/1ps
module mc_next_state
    import mc_pkg::*;
(
    input  mc_mode_e mode,
    input  logic     d,
    input  logic     q,
    input  logic     ce,
    output logic     nxt
);
    logic upd;

    always_comb begin
        unique case (mode)
            MC_TFF:   upd = q ^ d;
            MC_DFF:   upd = d;
            MC_COMB:  upd = d;
            MC_LATCH: upd = d;
        endcase
        nxt = ce ? upd : q;
    end
endmodule

// File: rtl/mc_storage.sv
`timescale 1ns/1ps
module mc_storage (
    input  logic eclk,
    input  logic aclr,
    input  logic apre,
    input  logic dual,
    input  logic nxt,
    input  logic lat_d,
    input  logic lat_en,
    output logic reg_q,
    output logic lat_q
);
    logic rise_q;
    logic fall_q;

    // Stored value is the XOR of the two half registers; each edge writes
    // its half so that the XOR equals the new value.
    always_ff @(posedge eclk or posedge aclr or posedge apre) begin
        if (aclr)      rise_q <= 1'b0;
        else if (apre) rise_q <= 1'b1;
        else           rise_q <= nxt ^ fall_q;
    end

    always_ff @(negedge eclk or posedge aclr or posedge apre) begin
        if (aclr | apre) fall_q <= 1'b0;
        else if (dual)   fall_q <= nxt ^ rise_q;
    end

    assign reg_q = rise_q ^ fall_q;

    always_latch begin
        if (aclr)                lat_q = 1'b0;
        else if (apre)           lat_q = 1'b1;
        else if (eclk & lat_en)  lat_q = lat_d;
    end
endmodule

// File: rtl/mc_macrocell.sv
`timescale 1ns/1ps
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_GCLK = 3,
    localparam int CSEL_W = $clog2(NUM_GCLK + 1)
) (
    input  logic                por_n,
    input  logic [NUM_GCLK-1:0] gclk,
    input  logic                pt_clk,
    input  logic                sop_in,
    input  logic                pin_in,
    input  logic                pt_ce,
    input  logic                pt_set,
    input  logic                pt_rst,
    input  logic                gsr,
    input  logic [1:0]          cfg_mode,
    input  logic                cfg_src_pin,
    input  logic [CSEL_W-1:0]   cfg_clk_sel,
    input  logic                cfg_clk_inv,
    input  logic                cfg_dual,
    input  logic                cfg_init,
    input  logic                cfg_gsr_en,
    output logic                mc_out
);
    mc_mode_e mode;
    logic     data;
    logic     eclk;
    logic     aclr;
    logic     apre;
    logic     nxt;
    logic     reg_q;
    logic     lat_q;

    assign mode = mc_mode_e'(cfg_mode);
    assign data = cfg_src_pin ? pin_in : sop_in;

    mc_clock_select #(.NUM_GCLK(NUM_GCLK)) u_clk (
        .gclk(gclk), .pt_clk(pt_clk), .sel(cfg_clk_sel),
        .inv(cfg_clk_inv), .eclk(eclk)
    );

    mc_async_ctrl u_async (
        .por_n(por_n), .init_val(cfg_init), .gsr(gsr), .gsr_en(cfg_gsr_en),
        .pt_set(pt_set), .pt_rst(pt_rst), .aclr(aclr), .apre(apre)
    );

    mc_next_state u_nxt (
        .mode(mode), .d(data), .q(reg_q), .ce(pt_ce), .nxt(nxt)
    );

    mc_storage u_store (
        .eclk(eclk), .aclr(aclr), .apre(apre), .dual(cfg_dual),
        .nxt(nxt), .lat_d(data), .lat_en(pt_ce),
        .reg_q(reg_q), .lat_q(lat_q)
    );

    always_comb begin
        unique case (mode)
            MC_COMB:  mc_out = data;
            MC_DFF:   mc_out = reg_q;
            MC_TFF:   mc_out = reg_q;
            MC_LATCH: mc_out = lat_q;
        endcase
    end
endmodule

// File: rtl/mc_macrocell_chk.sv
`timescale 1ns/1ps
module mc_macrocell_chk #(
    parameter int NUM_GCLK = 3,
    localparam int CSEL_W = $clog2(NUM_GCLK + 1)
) (
    input logic                por_n,
    input logic [NUM_GCLK-1:0] gclk,
    input logic                sop_in,
    input logic                pin_in,
    input logic                pt_ce,
    input logic                pt_set,
    input logic                pt_rst,
    input logic                gsr,
    input logic [1:0]          cfg_mode,
    input logic                cfg_src_pin,
    input logic [CSEL_W-1:0]   cfg_clk_sel,
    input logic                cfg_clk_inv,
    input logic                cfg_dual,
    input logic                cfg_init,
    input logic                cfg_gsr_en,
    input logic                mc_out
);
    logic smp_clk;
    logic dsel;
    logic async_any;
    logic simple_reg;

    assign smp_clk    = gclk[0];
    assign dsel       = cfg_src_pin ? pin_in : sop_in;
    assign async_any  = pt_set | pt_rst | (gsr & cfg_gsr_en);
    assign simple_reg = (cfg_mode == 2'd1 || cfg_mode == 2'd2) &&
                        cfg_clk_sel == '0 && !cfg_clk_inv && !cfg_dual;

    a_r1_pass_through: assert property (@(posedge smp_clk) disable iff (!por_n)
        (cfg_mode == 2'd0) |-> (mc_out == dsel));

    a_r2_d_capture: assert property (@(posedge smp_clk) disable iff (!por_n)
        (simple_reg && cfg_mode == 2'd1 && pt_ce && !async_any)
        |=> (async_any || mc_out == $past(dsel)));

    a_r5_ce_hold: assert property (@(posedge smp_clk) disable iff (!por_n)
        (simple_reg && !pt_ce && !async_any)
        |=> (async_any || $stable(mc_out)));

    a_r10_gsr_load: assert property (@(posedge smp_clk) disable iff (!por_n)
        (gsr && cfg_gsr_en && !pt_set && !pt_rst && cfg_mode != 2'd0)
        |-> (mc_out == cfg_init));

    a_r11_reset_wins: assert property (@(posedge smp_clk) disable iff (!por_n)
        (pt_rst && cfg_mode != 2'd0) |-> (mc_out == 1'b0));

    a_r11_set_forces: assert property (@(posedge smp_clk) disable iff (!por_n)
        (pt_set && !pt_rst && !(gsr && cfg_gsr_en && !cfg_init) && cfg_mode != 2'd0)
        |-> (mc_out == 1'b1));
endmodule

bind mc_macrocell mc_macrocell_chk #(.NUM_GCLK(NUM_GCLK)) u_chk (
    .por_n(por_n), .gclk(gclk), .sop_in(sop_in), .pin_in(pin_in),
    .pt_ce(pt_ce), .pt_set(pt_set), .pt_rst(pt_rst), .gsr(gsr),
    .cfg_mode(cfg_mode), .cfg_src_pin(cfg_src_pin), .cfg_clk_sel(cfg_clk_sel),
    .cfg_clk_inv(cfg_clk_inv), .cfg_dual(cfg_dual), .cfg_init(cfg_init),
    .cfg_gsr_en(cfg_gsr_en), .mc_out(mc_out)
);

// File: tb/test_mc_macrocell.sv
`timescale 1ns/1ps
module test_mc_macrocell;
    localparam int NUM_GCLK = 3;
    localparam int CSEL_W = $clog2(NUM_GCLK + 1);

    logic g0 = 1'b0, g1 = 1'b0, g2 = 1'b0;
    logic [NUM_GCLK-1:0] gclk;
    logic por_n = 1'b0, pt_clk = 1'b0, sop_in = 1'b0, pin_in = 1'b0;
    logic pt_ce = 1'b1, pt_set = 1'b0, pt_rst = 1'b0, gsr = 1'b0;
    logic [1:0] cfg_mode = 2'd1;
    logic cfg_src_pin = 1'b0, cfg_clk_inv = 1'b0, cfg_dual = 1'b0;
    logic cfg_init = 1'b0, cfg_gsr_en = 1'b0;
    logic [CSEL_W-1:0] cfg_clk_sel = '0;
    logic mc_out;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    assign gclk = {g2, g1, g0};
    always #2.5 g0 = ~g0;

    mc_macrocell #(.NUM_GCLK(NUM_GCLK)) i_mc_macrocell (
        .por_n(por_n), .gclk(gclk), .pt_clk(pt_clk), .sop_in(sop_in),
        .pin_in(pin_in), .pt_ce(pt_ce), .pt_set(pt_set), .pt_rst(pt_rst),
        .gsr(gsr), .cfg_mode(cfg_mode), .cfg_src_pin(cfg_src_pin),
        .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv),
        .cfg_dual(cfg_dual), .cfg_init(cfg_init), .cfg_gsr_en(cfg_gsr_en),
        .mc_out(mc_out)
    );

    task automatic chk(input string tag, input logic exp);
        n_chk++;
        if (mc_out !== exp) begin
            n_fail++;
            $display("FAIL %s: mc_out=%b expected %b", tag, mc_out, exp);
        end
    endtask

    task automatic setup(input logic [1:0] mode, input logic src, input int sel,
                         input logic inv, input logic dual, input logic init,
                         input logic gen);
        por_n = 0;
        g1 = 0; g2 = 0; pt_clk = 0; pt_ce = 1; pt_set = 0; pt_rst = 0; gsr = 0;
        sop_in = 0; pin_in = 0;
        cfg_mode = mode; cfg_src_pin = src; cfg_clk_sel = CSEL_W'(sel);
        cfg_clk_inv = inv; cfg_dual = dual; cfg_init = init; cfg_gsr_en = gen;
        #3 por_n = 1;
        #3;
    endtask

    task automatic pulse1();
        g1 = 1; #2; g1 = 0; #2;
    endtask

    task automatic t_reset();
        por_n = 0; cfg_mode = 2'd1; cfg_clk_sel = CSEL_W'(1); cfg_init = 1; #3;
        chk("R9 por low init1", 1'b1);
        por_n = 1; #3;
        chk("R9 after release init1", 1'b1);
        setup(2'd1, 0, 1, 0, 0, 0, 0);
        chk("R9 after release init0", 1'b0);
    endtask

    task automatic t_comb();
        setup(2'd0, 0, 1, 0, 0, 0, 0);
        sop_in = 1; #1; chk("R1 pass sop=1", 1'b1);
        sop_in = 0; #1; chk("R1 pass sop=0", 1'b0);
        setup(2'd0, 1, 1, 0, 0, 0, 0);
        pin_in = 1; sop_in = 0; #1; chk("R8 pass pin=1", 1'b1);
        pin_in = 0; sop_in = 1; #1; chk("R8 pass pin=0 sop ignored", 1'b0);
    endtask

    task automatic t_dff();
        setup(2'd1, 0, 1, 0, 0, 0, 0);
        sop_in = 1; #2; chk("R2 no edge yet", 1'b0);
        pulse1(); chk("R2 captured 1", 1'b1);
        sop_in = 0; g2 = 1; #2; g2 = 0; #2; chk("R7 unselected gclk2", 1'b1);
        pulse1(); chk("R2 captured 0", 1'b0);
        setup(2'd1, 0, NUM_GCLK, 0, 0, 0, 0);
        sop_in = 1; pulse1(); chk("R7 ptclk selected, gclk1 ignored", 1'b0);
        pt_clk = 1; #2; pt_clk = 0; #2; chk("R7 ptclk edge", 1'b1);
        setup(2'd1, 0, 1, 1, 0, 0, 0);
        sop_in = 1; g1 = 1; #2; chk("R7 inverted rising ignored", 1'b0);
        g1 = 0; #2; chk("R7 inverted falling captures", 1'b1);
        setup(2'd1, 1, 1, 0, 0, 0, 0);
        pin_in = 1; sop_in = 0; pulse1(); chk("R8 pin registered", 1'b1);
    endtask

    task automatic t_tff();
        setup(2'd2, 0, 1, 0, 0, 0, 0);
        sop_in = 1; pulse1(); chk("R3 toggle to 1", 1'b1);
        pulse1(); chk("R3 toggle to 0", 1'b0);
        pulse1(); chk("R3 toggle to 1 again", 1'b1);
        sop_in = 0; pulse1(); chk("R3 hold on t=0", 1'b1);
    endtask

    task automatic t_ce();
        setup(2'd1, 0, 1, 0, 0, 0, 0);
        pt_ce = 0; sop_in = 1; pulse1(); chk("R5 dff held", 1'b0);
        pt_ce = 1; pulse1(); chk("R5 dff enabled", 1'b1);
        setup(2'd2, 0, 1, 0, 0, 0, 0);
        pt_ce = 0; sop_in = 1; pulse1(); chk("R5 tff held", 1'b0);
    endtask

    task automatic t_latch();
        setup(2'd3, 0, 1, 0, 0, 0, 0);
        sop_in = 1; #2; chk("R4 closed gate", 1'b0);
        g1 = 1; #2; chk("R4 open follows 1", 1'b1);
        sop_in = 0; #2; chk("R4 open follows 0", 1'b0);
        pt_ce = 0; sop_in = 1; #2; chk("R4 ce low holds", 1'b0);
        pt_ce = 1; #2; chk("R4 ce high reopens", 1'b1);
        g1 = 0; #1; sop_in = 0; #2; chk("R4 gate low holds", 1'b1);
    endtask

    task automatic t_dual();
        setup(2'd1, 0, 1, 0, 1, 0, 0);
        sop_in = 1; g1 = 1; #2; chk("R6 dff rising", 1'b1);
        sop_in = 0; g1 = 0; #2; chk("R6 dff falling", 1'b0);
        setup(2'd2, 0, 1, 0, 1, 0, 0);
        sop_in = 1; g1 = 1; #2; chk("R6 tff rising", 1'b1);
        g1 = 0; #2; chk("R6 tff falling", 1'b0);
        g1 = 1; #2; chk("R6 tff rising again", 1'b1);
        setup(2'd2, 0, 1, 0, 0, 0, 0);
        sop_in = 1; g1 = 1; #2; g1 = 0; #2; chk("R6 single edge only once", 1'b1);
    endtask

    task automatic t_gsr();
        setup(2'd1, 0, 1, 0, 0, 1, 1);
        chk("R9 init1 loaded", 1'b1);
        sop_in = 0; pulse1(); chk("R10 cleared by data", 1'b0);
        gsr = 1; #2; chk("R10 gsr loads init1", 1'b1);
        gsr = 0; #2; chk("R10 held after gsr", 1'b1);
        setup(2'd1, 0, 1, 0, 0, 1, 0);
        sop_in = 0; pulse1();
        gsr = 1; #2; chk("R10 gsr disabled no effect", 1'b0);
        gsr = 0;
        setup(2'd1, 0, 1, 0, 0, 0, 1);
        sop_in = 1; pulse1();
        gsr = 1; #2; chk("R10 gsr loads init0", 1'b0);
        gsr = 0; #2;
    endtask

    task automatic t_setrst();
        setup(2'd1, 0, 1, 0, 0, 0, 0);
        pt_set = 1; #2; chk("R11 set forces 1", 1'b1);
        pt_set = 0; #2; chk("R11 held after set", 1'b1);
        pt_rst = 1; #2; chk("R11 reset forces 0", 1'b0);
        pt_set = 1; #2; chk("R11 reset beats set", 1'b0);
        pt_rst = 0; #2; chk("R11 set after reset ends", 1'b1);
        pt_set = 0; pt_rst = 1; sop_in = 1; pulse1(); chk("R11 reset beats clock", 1'b0);
        pt_rst = 0; #2;
        setup(2'd1, 0, 1, 0, 0, 1, 1);
        gsr = 1; pt_rst = 1; #2; chk("R11 reset beats gsr set", 1'b0);
        pt_rst = 0; #2; chk("R11 gsr set after reset", 1'b1);
        gsr = 0; #2;
    endtask

    task automatic t_gclk0();
        setup(2'd1, 0, 0, 0, 0, 0, 0);
        @(negedge g0); sop_in = 1; #0.5; chk("R7 gclk0 before edge", 1'b0);
        @(negedge g0); chk("R7 gclk0 captured", 1'b1);
        sop_in = 0;
        @(negedge g0); chk("R2 gclk0 captured 0", 1'b0);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_comb();
        t_dff();
        t_tff();
        t_ce();
        t_latch();
        t_dual();
        t_gsr();
        t_setrst();
        t_gclk0();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule